// File: doc/BRIEF.md
# CAN Node Control and Status Register

This block is the byte-wide control and status register that sits between a CPU register bus and a CAN protocol engine. Software uses the control byte to hand the transmit pin to the engine or leave it to general-purpose I/O, to mask the node-status interrupt, and to stop or restart bus operation. The engine reports its 2-bit fault-confinement state. The block watches that state, latches a sticky flag on every change, and raises an interrupt request when the mask allows it.

The halt bit does not read back as a plain storage bit. A read returns whether the engine is actually stopped, so software can see a stop forced by the hardware. When the node drops into bus off it stops at once. Restarting it takes a deliberate two-step sequence: a 1 written to the halt bit after bus-off entry, then a 0. A lone 0 write leaves the node stopped.

The register interface is single-cycle. A write takes effect at the clock edge where `wr_en` is high, and read data follows the address combinationally.

Top module: `can_node_csr`

## Requirements
- R1: After reset the control byte (address 0) reads 0x01: transmit enable off, interrupt enable off, node stopped. `engine_enable` and `irq` are 0, and the transition flag is clear.
- R2: Control bit 7 selects the pin source. When it is 1, `tx_pin` equals `engine_tx` and `tx_pin_oe` is 1. When it is 0, `tx_pin` equals `gpio_out` and `tx_pin_oe` equals `gpio_oe`.
- R3: Control bits 6 to 3 and bit 1 always read 0, whatever value was written to them.
- R4: Writing 1 to control bit 0 stops the node from the next clock. Bit 0 then reads 1 and `engine_enable` is 0.
- R5: Writing 0 to control bit 0 while the node status is not bus off restarts the node from the next clock. Bit 0 then reads 0 and `engine_enable` is 1.
- R6: Control bit 0 reads the live stop state, not the last value written. When the node status changes to 3 (bus off), bit 0 reads 1 and `engine_enable` drops in that same cycle, even if 0 was the last value written.
- R7: While the status is bus off, a 0 write to bit 0 restarts the node only if a 1 write to bit 0 has been accepted since bus-off entry. Otherwise the node stays stopped. A 1 written before the entry does not count.
- R8: Any change of node status sets the transition flag (status byte, address 1, bit 7) at the next clock. The flag stays set until software writes 0 to bit 7 of address 1. A write of 1 leaves it unchanged.
- R9: `irq` is high exactly when the transition flag is set and control bit 2 (interrupt enable) is 1.
- R10: Status byte bits 1:0 show the current node status, coded 0 error active, 1 warning, 2 error passive, 3 bus off. Bits 6:2 read 0.
- R11: `engine_enable` is always the inverse of the stop state that control bit 0 reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Byte address: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| node_status | input | 2 | Fault-confinement state from the engine |
| engine_tx | input | 1 | Transmit bit from the engine |
| gpio_out | input | 1 | General-purpose output level for the pin |
| gpio_oe | input | 1 | General-purpose output enable for the pin |
| tx_pin | output | 1 | Level driven toward the transmit pin |
| tx_pin_oe | output | 1 | Output enable for the transmit pin |
| engine_enable | output | 1 | Run permission for the protocol engine |
| irq | output | 1 | Node-status transition interrupt request |

## Verification
The hardest case to reach from the ports is restart from bus off. It depends on whether a 1 write was accepted after bus-off entry, and that state is never visible on a read. The bench drives the node into bus off from both the running and the halted state. It then tries a lone 0 write, checking that the node stays stopped, and follows with a 1-then-0 pair, checking that the node restarts while the status is still 3. The same-cycle stop on bus-off entry is checked by reading bit 0 between the status change and the next clock edge.

// File: rtl/can_csr_pkg.sv
package can_csr_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NS_W   = 2;

   typedef enum logic [NS_W-1:0] {
      NS_ACTIVE  = 2'd0,
      NS_WARNING = 2'd1,
      NS_PASSIVE = 2'd2,
      NS_BUSOFF  = 2'd3
   } node_state_e;

   localparam int unsigned CTL_TXEN_BIT = 7;
   localparam int unsigned CTL_IE_BIT   = 2;
   localparam int unsigned CTL_HALT_BIT = 0;
   localparam int unsigned STS_FLAG_BIT = 7;
endpackage

// File: rtl/can_csr_status_mon.sv
module can_csr_status_mon
   import can_csr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NS_W-1:0] status_i,
   input  logic            flag_clr_i,
   output logic [NS_W-1:0] status_o,
   output logic            flag_o,
   output logic            boff_entry_o
);
   logic [NS_W-1:0] st_s;
   logic [NS_W-1:0] st_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign st_s = status_i;
      end else begin : g_sync
         logic [NS_W-1:0] pipe [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= status_i;
               for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign st_s = pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_prev <= NS_ACTIVE;
         flag_o  <= 1'b0;
      end else begin
         st_prev <= st_s;
         if (st_s != st_prev)  flag_o <= 1'b1;
         else if (flag_clr_i)  flag_o <= 1'b0;
      end
   end

   assign status_o     = st_s;
   assign boff_entry_o = (st_s == NS_BUSOFF) && (st_prev != NS_BUSOFF);
endmodule

// File: rtl/can_csr_halt_ctl.sv
module can_csr_halt_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_wr_i,
   input  logic halt_val_i,
   input  logic bus_off_i,
   input  logic boff_entry_i,
   output logic stopped_o
);
   logic stopped_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stopped_q <= 1'b1;
         armed_q   <= 1'b0;
      end else if (boff_entry_i) begin
         stopped_q <= 1'b1;
         armed_q   <= 1'b0;
      end else if (halt_wr_i) begin
         if (halt_val_i) begin
            stopped_q <= 1'b1;
            armed_q   <= 1'b1;
         end else if (!bus_off_i || armed_q) begin
            stopped_q <= 1'b0;
            armed_q   <= 1'b0;
         end
      end
   end

   assign stopped_o = stopped_q | boff_entry_i;
endmodule

// File: rtl/can_csr_txmux.sv
module can_csr_txmux (
   input  logic sel_engine_i,
   input  logic engine_tx_i,
   input  logic gpio_out_i,
   input  logic gpio_oe_i,
   output logic pin_o,
   output logic pin_oe_o
);
   always_comb begin
      if (sel_engine_i) begin
         pin_o    = engine_tx_i;
         pin_oe_o = 1'b1;
      end else begin
         pin_o    = gpio_out_i;
         pin_oe_o = gpio_oe_i;
      end
   end
endmodule

// File: rtl/can_node_csr.sv
module can_node_csr
   import can_csr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 1,
   parameter int unsigned CTRL_ADDR   = 0,
   parameter int unsigned STAT_ADDR   = 1,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NS_W-1:0]   node_status,
   input  logic              engine_tx,
   input  logic              gpio_out,
   input  logic              gpio_oe,
   output logic              tx_pin,
   output logic              tx_pin_oe,
   output logic              engine_enable,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("can_node_csr: DATA_W must be 8");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("can_node_csr: control and status addresses collide");
      end
      if ((CTRL_ADDR >> ADDR_W) != 0 || (STAT_ADDR >> ADDR_W) != 0) begin : g_bad_range
         $error("can_node_csr: address outside ADDR_W");
      end
   endgenerate

   logic            ctl_wr, sts_wr;
   logic            txen_q, ie_q;
   logic            stopped;
   logic            flag;
   logic            boff_entry;
   logic [NS_W-1:0] status_s;
   logic            unused_wr_bits;

   assign ctl_wr = wr_en && (addr == CTRL_A);
   assign sts_wr = wr_en && (addr == STAT_A);
   assign unused_wr_bits = ^{wr_data[6:3], wr_data[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txen_q <= 1'b0;
         ie_q   <= 1'b0;
      end else if (ctl_wr) begin
         txen_q <= wr_data[CTL_TXEN_BIT];
         ie_q   <= wr_data[CTL_IE_BIT];
      end
   end

   can_csr_status_mon #(.SYNC_STAGES(SYNC_STAGES)) u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .status_i     (node_status),
      .flag_clr_i   (sts_wr && !wr_data[STS_FLAG_BIT]),
      .status_o     (status_s),
      .flag_o       (flag),
      .boff_entry_o (boff_entry)
   );

   can_csr_halt_ctl u_halt (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_wr_i    (ctl_wr),
      .halt_val_i   (wr_data[CTL_HALT_BIT]),
      .bus_off_i    (status_s == NS_BUSOFF),
      .boff_entry_i (boff_entry),
      .stopped_o    (stopped)
   );

   can_csr_txmux u_txmux (
      .sel_engine_i (txen_q),
      .engine_tx_i  (engine_tx),
      .gpio_out_i   (gpio_out),
      .gpio_oe_i    (gpio_oe),
      .pin_o        (tx_pin),
      .pin_oe_o     (tx_pin_oe)
   );

   always_comb begin
      rd_data = '0;
      if (addr == CTRL_A) begin
         rd_data[CTL_TXEN_BIT] = txen_q;
         rd_data[CTL_IE_BIT]   = ie_q;
         rd_data[CTL_HALT_BIT] = stopped;
      end else if (addr == STAT_A) begin
         rd_data[STS_FLAG_BIT] = flag;
         rd_data[NS_W-1:0]     = status_s;
      end
   end

   assign engine_enable = !stopped;
   assign irq           = flag && ie_q;
endmodule

// File: rtl/can_node_csr_chk.sv
module can_node_csr_chk
   import can_csr_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            addr,
   input logic [7:0]      wr_data,
   input logic [7:0]      rd_data,
   input logic [NS_W-1:0] status_s,
   input logic            flag,
   input logic            txen_q,
   input logic            engine_tx,
   input logic            tx_pin,
   input logic            tx_pin_oe,
   input logic            engine_enable
);
   logic past_valid;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   a_r2_engine_route: assert property (@(posedge clk) disable iff (!rst_n)
      txen_q |-> (tx_pin == engine_tx && tx_pin_oe));

   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 1'b0) |-> (rd_data[6:3] == 4'b0 && rd_data[1] == 1'b0));

   a_r4_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 1'b0 && wr_data[0]) |=> !engine_enable);

   a_r5_cancel_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 1'b0 && !wr_data[0] && status_s != NS_BUSOFF)
      |=> (engine_enable || status_s == NS_BUSOFF));

   a_r6_busoff_entry_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && status_s == NS_BUSOFF && $past(status_s) != NS_BUSOFF)
      |-> !engine_enable);

   a_r8_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && status_s != $past(status_s)) |=> flag);
endmodule

bind can_node_csr can_node_csr_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .addr          (addr[0]),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .status_s      (status_s),
   .flag          (flag),
   .txen_q        (txen_q),
   .engine_tx     (engine_tx),
   .tx_pin        (tx_pin),
   .tx_pin_oe     (tx_pin_oe),
   .engine_enable (engine_enable)
);

// File: tb/can_node_csr_tb_top.sv
`timescale 1ns/1ps
module can_node_csr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [0:0] addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [1:0] node_status = 2'd0;
   logic       engine_tx = 1'b0, gpio_out = 1'b0, gpio_oe = 1'b0;
   logic       tx_pin, tx_pin_oe, engine_enable, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   can_node_csr dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .node_status(node_status), .engine_tx(engine_tx),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .tx_pin(tx_pin),
      .tx_pin_oe(tx_pin_oe), .engine_enable(engine_enable), .irq(irq)
   );

   // {txen, engine_tx, gpio_out, gpio_oe, exp_pin, exp_oe}
   localparam logic [5:0] MUX_VEC [8] = '{
      6'b0_0_1_1_1_1, 6'b0_1_0_1_0_1, 6'b0_1_1_0_1_0, 6'b0_0_0_0_0_0,
      6'b1_1_0_0_1_1, 6'b1_0_1_1_0_1, 6'b1_1_1_0_1_1, 6'b1_0_0_0_0_1
   };
   localparam logic [1:0] NS_SEQ [4] = '{2'd1, 2'd2, 2'd1, 2'd0};

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] exp, input string req);
      addr = a; wr_en = 1'b0;
      #1 check(req, rd_data, exp);
   endtask

   task automatic set_ns(input logic [1:0] s);
      @(negedge clk);
      node_status = s;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(1'b0, 8'h01, "R1 ctrl reset");
      check("R1 engine_enable reset", {7'b0, engine_enable}, 8'h00);
      check("R1 irq reset", {7'b0, irq}, 8'h00);
      rd(1'b1, 8'h00, "R1 status reset");

      // R3 reserved bits, R5 cancel when not bus off
      wr(1'b0, 8'hFE);
      rd(1'b0, 8'h84, "R3 reserved read zero / R5 cancel");
      check("R5 engine_enable after cancel", {7'b0, engine_enable}, 8'h01);
      check("R11 enable matches bit0", {7'b0, engine_enable}, {7'b0, ~rd_data[0]});
      // R4 halt request
      wr(1'b0, 8'h85);
      rd(1'b0, 8'h85, "R4 halt read");
      check("R4 engine_enable halted", {7'b0, engine_enable}, 8'h00);
      wr(1'b0, 8'h84);
      rd(1'b0, 8'h84, "R5 restart");

      // R2 pin routing table
      foreach (MUX_VEC[i]) begin
         wr(1'b0, MUX_VEC[i][5] ? 8'h84 : 8'h04);
         engine_tx = MUX_VEC[i][4]; gpio_out = MUX_VEC[i][3]; gpio_oe = MUX_VEC[i][2];
         #1 check("R2 pin route", {6'b0, tx_pin, tx_pin_oe}, {6'b0, MUX_VEC[i][1:0]});
      end

      // R8/R10 status changes, flag set and clear; R9 with ie=1
      wr(1'b0, 8'h84);
      foreach (NS_SEQ[i]) begin
         set_ns(NS_SEQ[i]);
         rd(1'b1, {1'b1, 5'b0, NS_SEQ[i]}, "R8/R10 flag set and status");
         check("R9 irq with enable", {7'b0, irq}, 8'h01);
         wr(1'b1, 8'h7F);
         rd(1'b1, {6'b0, NS_SEQ[i]}, "R8 flag cleared by 0");
         check("R9 irq after clear", {7'b0, irq}, 8'h00);
      end
      // R8 write 1 has no effect on clear flag or set flag
      wr(1'b1, 8'hFF);
      rd(1'b1, 8'h00, "R8 write 1 leaves flag clear");
      set_ns(2'd2);
      wr(1'b1, 8'h80);
      rd(1'b1, 8'h82, "R8 write 1 leaves flag set");
      // R9 masking
      wr(1'b0, 8'h80);
      check("R9 irq masked", {7'b0, irq}, 8'h00);
      wr(1'b0, 8'h84);
      check("R9 irq unmasked", {7'b0, irq}, 8'h01);
      wr(1'b1, 8'h00);

      // R6 bus-off entry from running, same-cycle stop
      @(negedge clk);
      addr = 1'b0; node_status = 2'd3;
      #1 check("R6 stop on bus-off entry", rd_data, 8'h85);
      check("R6 engine_enable same cycle", {7'b0, engine_enable}, 8'h00);
      // R7 lone 0 ignored, 1 then 0 restarts
      wr(1'b0, 8'h84);
      rd(1'b0, 8'h85, "R7 lone 0 write ignored in bus off");
      wr(1'b0, 8'h85);
      wr(1'b0, 8'h84);
      rd(1'b0, 8'h84, "R7 1 then 0 restarts");
      check("R7 engine_enable after recovery", {7'b0, engine_enable}, 8'h01);
      set_ns(2'd0);

      // R7 a 1 written before entry does not count
      wr(1'b0, 8'h85);
      set_ns(2'd3);
      wr(1'b0, 8'h84);
      rd(1'b0, 8'h85, "R7 pre-entry 1 not counted");
      wr(1'b0, 8'h85);
      wr(1'b0, 8'h84);
      rd(1'b0, 8'h84, "R7 recovery after fresh 1");
      set_ns(2'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule